// File: doc/BRIEF.md
# AXI write burst issuer

This block turns a stream of write jobs into AXI4 write bursts. Each job carries a start address, a length in bytes and an ID. The payload arrives on a separate stream with a valid/ready handshake. For each job the block issues one address beat with the burst fields worked out from the length. It then passes the payload words through to the write data channel and marks the final beat. When the last byte count is not a whole word, the final beat carries a reduced byte strobe.

A small metadata FIFO keeps the ID of every address handshake that has no write response yet. When a response arrives, the oldest ID is shown on the completion output. The depth of this FIFO caps the number of outstanding bursts.

The address and data phases of consecutive jobs are serialised. A new job is taken only after the previous write burst has ended, and its address beat follows one cycle later. The design suits a single, in-order write stream whose jobs have already been split into legal bursts: non-zero length, word-aligned start, no 4 KiB crossing, at most `MAX_BEATS` beats.

The controller has three states:
- `ST_IDLE`: accepts a job. The transition IDLE→ADDR happens on the job handshake.
- `ST_ADDR`: drives the address beat. The transition ADDR→DATA happens on the address handshake.
- `ST_DATA`: moves the payload. The transition DATA→IDLE happens on the handshake of the last beat.

Top module: `axi_wr_burst_issuer`

## Requirements
- R1: After reset, aw_valid, w_valid and done_valid are low and job_ready is high.
- R2: The address beat carries the job address and ID. aw_len is ceil(len/bytes-per-beat)-1, aw_size is log2(bytes-per-beat) and aw_burst is 2'b01 (incrementing). All of these stay stable while aw_valid waits for aw_ready.
- R3: aw_valid is never high while a write burst is in progress. The next job's address beat comes only after the previous burst's last beat.
- R4: Each burst moves exactly aw_len+1 beats. w_data is the user data word in stream order, w_valid follows data_valid during the burst, and w_last is high on the final beat only.
- R5: Every beat except the last has all strobe bits set. On the last beat, strobe bit i is set when i < (len mod bytes-per-beat), and all bits are set when that remainder is zero.
- R6: data_ready equals w_ready while a burst is in progress and is low otherwise, so no user data is consumed outside a burst.
- R7: Every write data beat carries the burst's ID on w_id.
- R8: At most META_DEPTH address handshakes are outstanding without a write response. While that many are outstanding, aw_valid stays low.
- R9: done_valid is raised with b_valid while a burst is outstanding. done_id gives the job IDs in address-beat order. b_ready is done_ready gated by an outstanding burst, so a completion is held until taken.
- R10: job_ready is high exactly when no job is between acceptance and the end of its write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job offered |
| job_ready | output | 1 | Job taken |
| job_addr | input | ADDR_W | Word-aligned start address |
| job_len_bytes | input | LEN_W | Length in bytes, 1..MAX_BEATS*DATA_W/8 |
| job_id | input | ID_W | Job ID |
| data_valid | input | 1 | User data word offered |
| data_ready | output | 1 | User data word taken |
| data_in | input | DATA_W | User data word |
| done_ready | input | 1 | Completion taken |
| done_valid | output | 1 | Completion present |
| done_id | output | ID_W | ID of completed job |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Burst start address |
| aw_len | output | 8 | Beats minus one |
| aw_size | output | 3 | log2 bytes per beat |
| aw_burst | output | 2 | Burst type, incrementing |
| aw_id | output | ID_W | Burst ID |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | DATA_W | Write data |
| w_strb | output | DATA_W/8 | Byte strobes |
| w_last | output | 1 | Last beat of burst |
| w_id | output | ID_W | Burst ID on data beats |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |

## Verification
The bench first runs jobs with every ready held high. These jobs cover a single byte, a full 16-beat burst, an odd 7-byte length and a whole-word length. Together they separate the strobe and beat-count cases and show the two-cycle gap between bursts. Twenty jobs of random length then run under random backpressure on the address, data, user and completion sides, which exposes any handshake that is not held or any data consumed outside a burst. A final pattern withholds write responses while six short jobs wait. The address beats must then stop at the FIFO depth and resume in order once responses flow.

// File: rtl/wbi_pkg.sv
package wbi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } wbi_state_e;
endpackage

// File: rtl/wbi_meta_fifo.sv
module wbi_meta_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // R8: never written beyond its depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9: never read when nothing is outstanding
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/wbi_last_strb.sv
module wbi_last_strb #(
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 7,
    parameter bit UNALIGNED = 1'b1
) (
    input  logic [LEN_W-1:0]    len_bytes,
    output logic [DATA_W/8-1:0] strb
);
    localparam int BPB    = DATA_W / 8;
    localparam int SIZE_L = $clog2(BPB);

    logic unused_len;
    assign unused_len = ^len_bytes;

    generate
        if (UNALIGNED && SIZE_L > 0) begin : g_partial
            logic [SIZE_L-1:0] rem;
            assign rem = len_bytes[SIZE_L-1:0];
            always_comb begin
                for (int i = 0; i < BPB; i++)
                    strb[i] = (rem == '0) || (i < int'(rem));
            end
        end else begin : g_full
            assign strb = '1;
        end
    endgenerate
endmodule

// File: rtl/axi_wr_burst_issuer.sv
module axi_wr_burst_issuer #(
    parameter int ADDR_W     = 32,
    parameter int ID_W       = 4,
    parameter int DATA_W     = 32,
    parameter int MAX_BEATS  = 16,
    parameter int META_DEPTH = 4,
    parameter bit UNALIGNED  = 1'b1,
    parameter bit SET_WID    = 1'b1,
    localparam int BPB       = DATA_W / 8,
    localparam int LEN_W     = $clog2(MAX_BEATS * BPB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_valid,
    output logic              job_ready,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [LEN_W-1:0]  job_len_bytes,
    input  logic [ID_W-1:0]   job_id,
    input  logic              data_valid,
    output logic              data_ready,
    input  logic [DATA_W-1:0] data_in,
    input  logic              done_ready,
    output logic              done_valid,
    output logic [ID_W-1:0]   done_id,
    output logic              aw_valid,
    input  logic              aw_ready,
    output logic [ADDR_W-1:0] aw_addr,
    output logic [7:0]        aw_len,
    output logic [2:0]        aw_size,
    output logic [1:0]        aw_burst,
    output logic [ID_W-1:0]   aw_id,
    output logic              w_valid,
    input  logic              w_ready,
    output logic [DATA_W-1:0] w_data,
    output logic [BPB-1:0]    w_strb,
    output logic              w_last,
    output logic [ID_W-1:0]   w_id,
    input  logic              b_valid,
    output logic              b_ready
);
    import wbi_pkg::*;

    localparam int SIZE_L = $clog2(BPB);

    wbi_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        alen_q;
    logic [ID_W-1:0]   id_q;
    logic [BPB-1:0]    lstrb_q, lstrb_d;
    logic [7:0]        beat_q;
    logic [LEN_W-1:0]  len_m1;
    logic              take_job, aw_fire, w_fire, is_last;
    logic              meta_full, meta_empty, b_fire;

    wbi_last_strb #(.DATA_W(DATA_W), .LEN_W(LEN_W), .UNALIGNED(UNALIGNED)) u_strb (
        .len_bytes (job_len_bytes),
        .strb      (lstrb_d)
    );

    wbi_meta_fifo #(.WIDTH(ID_W), .DEPTH(META_DEPTH)) u_meta (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (aw_fire),
        .push_data (id_q),
        .pop       (b_fire),
        .head      (done_id),
        .full      (meta_full),
        .empty     (meta_empty)
    );

    assign len_m1   = job_len_bytes - LEN_W'(1);
    assign take_job = job_valid && job_ready;
    assign aw_fire  = aw_valid && aw_ready;
    assign w_fire   = w_valid && w_ready;
    assign is_last  = (beat_q == alen_q);
    assign b_fire   = b_valid && b_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take_job)           state_d = ST_ADDR;
            ST_ADDR: if (aw_fire)            state_d = ST_DATA;
            ST_DATA: if (w_fire && is_last)  state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Burst context and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            alen_q  <= '0;
            id_q    <= '0;
            lstrb_q <= '1;
            beat_q  <= '0;
        end else begin
            if (take_job) begin
                addr_q  <= job_addr;
                alen_q  <= 8'(len_m1 >> SIZE_L);
                id_q    <= job_id;
                lstrb_q <= lstrb_d;
            end
            if (aw_fire)     beat_q <= '0;
            else if (w_fire) beat_q <= beat_q + 8'd1;
        end
    end

    // Outputs
    always_comb begin
        job_ready  = 1'b0;
        aw_valid   = 1'b0;
        w_valid    = 1'b0;
        data_ready = 1'b0;
        w_last     = 1'b0;
        unique case (state_q)
            ST_IDLE: job_ready = 1'b1;
            ST_ADDR: aw_valid  = !meta_full;
            ST_DATA: begin
                w_valid    = data_valid;
                data_ready = w_ready;
                w_last     = is_last;
            end
            default: ;
        endcase
    end

    assign aw_addr  = addr_q;
    assign aw_len   = alen_q;
    assign aw_size  = 3'(SIZE_L);
    assign aw_burst = 2'b01;
    assign aw_id    = id_q;
    assign w_data   = data_in;
    assign w_strb   = is_last ? lstrb_q : '1;

    generate
        if (SET_WID) begin : g_wid
            assign w_id = id_q;
        end else begin : g_nowid
            assign w_id = '0;
        end
    endgenerate

    assign done_valid = b_valid && !meta_empty;
    assign b_ready    = done_ready && !meta_empty;

    // R1: outputs idle in the first cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !aw_valid && !w_valid && job_ready);
    // R2: address beat held stable until accepted
    a_r2_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_len) && $stable(aw_id));
    // R3: no address beat while data beats flow
    a_r3_no_aw_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid |-> !aw_valid);
    // R4: the burst ends after the beat marked last
    a_r4_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
        w_valid && w_ready && w_last |=> !w_valid && !data_ready);
    // R6: user data only consumed during a burst
    a_r6_data_gated: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> !job_ready && !aw_valid);
    // R9: completion held until taken (response channel holds b_valid)
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !done_ready && b_valid |=> done_valid && $stable(done_id));
endmodule

// File: tb/tb_axi_wr_burst_issuer.sv
`timescale 1ns/1ps
module tb_axi_wr_burst_issuer;
    localparam int ADDR_W = 32, ID_W = 4, DATA_W = 32, MAX_BEATS = 16, META_DEPTH = 4;
    localparam int BPB   = DATA_W / 8;
    localparam int LEN_W = $clog2(MAX_BEATS * BPB + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic job_valid = 0, job_ready;
    logic [ADDR_W-1:0] job_addr = '0;
    logic [LEN_W-1:0] job_len_bytes = '0;
    logic [ID_W-1:0] job_id = '0;
    logic data_valid = 0, data_ready;
    logic [DATA_W-1:0] data_in = '0;
    logic done_ready = 0, done_valid;
    logic [ID_W-1:0] done_id;
    logic aw_valid, aw_ready = 0;
    logic [ADDR_W-1:0] aw_addr;
    logic [7:0] aw_len;
    logic [2:0] aw_size;
    logic [1:0] aw_burst;
    logic [ID_W-1:0] aw_id;
    logic w_valid, w_ready = 0;
    logic [DATA_W-1:0] w_data;
    logic [BPB-1:0] w_strb;
    logic w_last;
    logic [ID_W-1:0] w_id;
    logic b_valid = 0, b_ready;

    axi_wr_burst_issuer #(.ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W),
        .MAX_BEATS(MAX_BEATS), .META_DEPTH(META_DEPTH), .UNALIGNED(1'b1), .SET_WID(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
        .job_addr(job_addr), .job_len_bytes(job_len_bytes), .job_id(job_id),
        .data_valid(data_valid), .data_ready(data_ready), .data_in(data_in),
        .done_ready(done_ready), .done_valid(done_valid), .done_id(done_id),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
        .aw_size(aw_size), .aw_burst(aw_burst), .aw_id(aw_id),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
        .w_last(w_last), .w_id(w_id), .b_valid(b_valid), .b_ready(b_ready));

    int n_chk = 0, n_fail = 0;
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    bit busy = 0, active = 0, b_en = 1, rnd = 0;
    int outstanding = 0, bi = 0, dexp = 0, bpend = 0, aw_count = 0;
    bit hs_job = 0, hs_aw = 0, hs_w = 0, hs_wlast = 0, hs_b = 0;
    logic [ADDR_W-1:0] q_addr[$];
    int q_len[$], q_id[$], wq_beats[$], wq_strb[$], wq_id[$], dq_id[$];

    function automatic int exp_strb(input int len);
        int rem;
        rem = len % BPB;
        return (rem == 0) ? ((1 << BPB) - 1) : ((1 << rem) - 1);
    endfunction

    always @(negedge clk) begin
        hs_job = 0; hs_aw = 0; hs_w = 0; hs_wlast = 0; hs_b = 0;
        if (rst_n) begin
            hs_job = job_valid && job_ready;
            hs_aw  = aw_valid && aw_ready;
            hs_w   = w_valid && w_ready;
            hs_b   = b_valid && b_ready;
            chk("R10 job_ready", job_ready, !busy);
            chk("R3/R8 aw_valid", aw_valid, busy && !active && outstanding < META_DEPTH);
            chk("R6 data_ready", data_ready, active && w_ready);
            chk("R4 w_valid", w_valid, active && data_valid);
            chk("R9 b_ready", b_ready, done_ready && outstanding > 0);
            chk("R9 done_valid", done_valid, b_valid && outstanding > 0);
            if (hs_job) begin
                q_addr.push_back(job_addr); q_len.push_back(int'(job_len_bytes));
                q_id.push_back(int'(job_id));
            end
            if (hs_aw) begin
                if (q_addr.size() == 0) chk("R2 unexpected aw", 1, 0);
                else begin
                    int len, id;
                    len = q_len.pop_front(); id = q_id.pop_front();
                    chk("R2 aw_addr", aw_addr, q_addr.pop_front());
                    chk("R2 aw_len", aw_len, (len + BPB - 1) / BPB - 1);
                    chk("R2 aw_size", aw_size, 2);
                    chk("R2 aw_burst", aw_burst, 1);
                    chk("R2 aw_id", aw_id, id);
                    wq_beats.push_back((len + BPB - 1) / BPB);
                    wq_strb.push_back(exp_strb(len));
                    wq_id.push_back(id);
                    dq_id.push_back(id);
                end
            end
            if (hs_w) begin
                if (wq_beats.size() == 0) chk("R4 unexpected w", 1, 0);
                else begin
                    bit last;
                    last = (bi == wq_beats[0] - 1);
                    chk("R4 w_data", w_data, 32'(dexp));
                    chk("R4 w_last", w_last, last);
                    chk("R5 w_strb", w_strb, last ? wq_strb[0] : (1 << BPB) - 1);
                    chk("R7 w_id", w_id, wq_id[0]);
                    if (last) begin
                        hs_wlast = 1;
                        void'(wq_beats.pop_front()); void'(wq_strb.pop_front());
                        void'(wq_id.pop_front());
                    end
                end
            end
            if (hs_b) begin
                if (dq_id.size() == 0) chk("R9 unexpected b", 1, 0);
                else chk("R9 done_id", done_id, dq_id.pop_front());
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 0; active = 0; outstanding = 0; bi = 0; dexp = 0; bpend = 0;
            aw_ready <= 0; w_ready <= 0; done_ready <= 0; data_valid <= 0;
            data_in <= '0; b_valid <= 0;
        end else begin
            if (hs_job) busy = 1;
            if (hs_aw) begin active = 1; outstanding++; bi = 0; aw_count++; end
            if (hs_w) begin
                dexp++;
                if (hs_wlast) begin active = 0; busy = 0; bpend++; end
                else bi++;
            end
            if (hs_b) begin outstanding--; bpend--; end
            data_in <= 32'(dexp);
            if (hs_b) b_valid <= 0;
            else if (!b_valid && b_en && bpend > 0) b_valid <= 1;
            aw_ready   <= rnd ? 1'($urandom % 2) : 1'b1;
            w_ready    <= rnd ? 1'($urandom % 2) : 1'b1;
            done_ready <= rnd ? 1'($urandom % 2) : 1'b1;
            if (!(data_valid && !hs_w)) data_valid <= rnd ? 1'($urandom % 2) : 1'b1;
        end
    end

    task automatic send_job(input logic [ADDR_W-1:0] a, input int len, input int id);
        @(posedge clk);
        job_valid <= 1; job_addr <= a; job_len_bytes <= LEN_W'(len); job_id <= ID_W'(id);
        do @(negedge clk); while (!job_ready);
    endtask

    task automatic end_jobs();
        @(posedge clk);
        job_valid <= 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || outstanding > 0 || q_addr.size() > 0 || job_valid);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        rst_n <= 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 aw_valid", aw_valid, 0);
        chk("R1 w_valid", w_valid, 0);
        chk("R1 done_valid", done_valid, 0);
        chk("R1 job_ready", job_ready, 1);

        // All ready: 1-beat, 16-beat full (R2 R4), 7 bytes (R5), 1 byte, 16 bytes
        send_job(32'h1000, 4, 1);
        send_job(32'h2000, 64, 2);
        send_job(32'h3000, 7, 3);
        send_job(32'h3100, 1, 4);
        send_job(32'h4000, 16, 5);
        end_jobs();
        wait_idle();

        // Random backpressure everywhere (R3 R6 R7 R9)
        rnd = 1;
        for (int i = 0; i < 20; i++)
            send_job(32'h8000 + 32'(i) * 32'h100, 1 + int'($urandom % 64), i % 16);
        end_jobs();
        wait_idle();

        // Responses withheld: address beats cap at META_DEPTH (R8)
        rnd = 0; b_en = 0; aw_count = 0;
        fork
            begin
                for (int i = 0; i < 6; i++) send_job(32'hA000 + 32'(i) * 32'h40, 4, 10 + i);
                end_jobs();
            end
            begin
                repeat (80) @(negedge clk);
                chk("R8 outstanding cap", aw_count, META_DEPTH);
                chk("R8 aw stalled", aw_valid, 0);
                b_en = 1;
            end
        join
        wait_idle();
        repeat (5) @(negedge clk);
        summary();
    end
endmodule